// File: doc/BRIEF.md
# Port-to-Port Mailbox Interrupt Logic

This block sits next to a two-port shared memory. It lets either port raise an interrupt on the other port by writing to a reserved mailbox word. It watches the chip enable, read/write and output enable strobes and the address of both ports on every clock. It keeps one pending flag per port and drives that flag out as an active-low interrupt. The mailbox data itself stays in the shared memory, so this block handles only signalling.

The two highest addresses are reserved. The top word (all ones) is the right port's mailbox. The word just below it (all ones minus one) is the left port's mailbox. A port raises its peer's interrupt by writing the peer's mailbox. The owner acknowledges by reading its own mailbox, and the clear takes effect when that read access ends because the owner releases chip enable or output enable. If a new message arrives in the same cycle as an acknowledge, the new message wins.

Top module: `mailbox_irq`

## Requirements
- R1: While reset is asserted, and after it is released, both `lIntN` and `rIntN` are high until a mailbox write occurs.
- R2: A left-port write (`lCeN`=0, `lRwN`=0) to the top address (all ones, 0x3FF with the default 10-bit address) drives `rIntN` low from the clock edge that samples the write onward. `lOeN` has no effect on the write.
- R3: A right-port write (`rCeN`=0, `rRwN`=0) to the top address minus one (0x3FE) drives `lIntN` low from the clock edge that samples the write onward.
- R4: A right-port read of 0x3FF (`rCeN`=0, `rOeN`=0, `rRwN`=1) does not change `rIntN` while the read is held. In the first cycle after that read in which `rCeN` or `rOeN` is high, `rIntN` returns high at the next edge.
- R5: A left-port read of 0x3FE (`lCeN`=0, `lOeN`=0, `lRwN`=1) followed by a cycle with `lCeN` or `lOeN` high returns `lIntN` high. The read alone does not clear it.
- R6: Accesses that match neither rule leave both interrupts unchanged. This covers any access to an address below 0x3FE, a port reading the peer's mailbox, and a port writing its own mailbox.
- R7: If a set and an acknowledge hit the same interrupt in the same cycle, the interrupt stays low (set wins).
- R8: A mailbox read that ends by moving the address away, or by driving read/write low while both enables stay low, does not clear the interrupt. Only the release of an enable ends an acknowledging read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock on which all strobes are sampled |
| rstN | input | 1 | Asynchronous active-low reset |
| lCeN | input | 1 | Left port chip enable, active low |
| lRwN | input | 1 | Left port read/write: 1 read, 0 write |
| lOeN | input | 1 | Left port output enable, active low |
| lAddr | input | ADDR_W | Left port word address |
| rCeN | input | 1 | Right port chip enable, active low |
| rRwN | input | 1 | Right port read/write: 1 read, 0 write |
| rOeN | input | 1 | Right port output enable, active low |
| rAddr | input | ADDR_W | Right port word address |
| lIntN | output | 1 | Left port interrupt, active low |
| rIntN | output | 1 | Right port interrupt, active low |

## Verification
The bench targets the acknowledge path in four ways. It holds a read over several cycles to catch a design that clears on the read itself rather than on the enable release. It ends reads by an address change or a read/write flip to catch a design that treats any end of match as an acknowledge. It lines up a peer write with the enable release to expose clear-over-set priority, which would silently lose a message. It has ports read the peer's mailbox and write their own, which catches a swapped address decode or a swapped interrupt. A long stretch of random strobes concentrated on the top addresses is then compared against a behavioural model on every clock.

// File: rtl/mailbox_irq_pkg.sv
package mailbox_irq_pkg;
  localparam int PORTS = 2;
  localparam int LEFT  = 0;
  localparam int RIGHT = 1;

  // Per-cycle requests from the control to the flag registers.
  typedef struct packed {
    logic [PORTS-1:0] setFlag;
    logic [PORTS-1:0] clrFlag;
  } mbxStrobe_t;
endpackage

// File: rtl/mailbox_irq_ctrl.sv
module mailbox_irq_ctrl
  import mailbox_irq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [PORTS-1:0]             ceN,
  input  logic [PORTS-1:0]             rwN,
  input  logic [PORTS-1:0]             oeN,
  input  logic [PORTS-1:0][ADDR_W-1:0] addr,
  output mbxStrobe_t                   strobe
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic [PORTS-1:0] setVec;
  logic [PORTS-1:0] clrVec;
  logic [PORTS-1:0] readNow;
  logic [PORTS-1:0] readHeld;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    localparam int PEER = PORTS - 1 - p;
    // Mailbox of port q sits at TOP - (PORTS-1-q).
    localparam logic [ADDR_W-1:0] OWN_BOX  = TOP_ADDR - ADDR_W'(PORTS - 1 - p);
    localparam logic [ADDR_W-1:0] PEER_BOX = TOP_ADDR - ADDR_W'(p);

    logic writePeer;
    assign writePeer  = !ceN[p] && !rwN[p] && (addr[p] == PEER_BOX);
    assign setVec[PEER] = writePeer;

    assign readNow[p] = !ceN[p] && !oeN[p] && rwN[p] && (addr[p] == OWN_BOX);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) readHeld[p] <= 1'b0;
      else       readHeld[p] <= readNow[p];
    end

    // Acknowledge happens when an enable is released after a mailbox read.
    assign clrVec[p] = readHeld[p] && (ceN[p] || oeN[p]);
  end

  assign strobe = '{setFlag: setVec, clrFlag: clrVec};
endmodule

// File: rtl/mailbox_irq_flags.sv
module mailbox_irq_flags
  import mailbox_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  mbxStrobe_t       strobe,
  output logic [PORTS-1:0] intN
);
  logic [PORTS-1:0] pending;

  for (genvar p = 0; p < PORTS; p++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    pending[p] <= 1'b0;
      else if (strobe.setFlag[p])   pending[p] <= 1'b1;
      else if (strobe.clrFlag[p])   pending[p] <= 1'b0;
    end
    assign intN[p] = !pending[p];
  end
endmodule

// File: rtl/mailbox_irq.sv
module mailbox_irq
  import mailbox_irq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCeN,
  input  logic              lRwN,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              rCeN,
  input  logic              rRwN,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  output logic              lIntN,
  output logic              rIntN
);
  logic [PORTS-1:0]             ceVec;
  logic [PORTS-1:0]             rwVec;
  logic [PORTS-1:0]             oeVec;
  logic [PORTS-1:0][ADDR_W-1:0] addrVec;
  logic [PORTS-1:0]             intVec;
  mbxStrobe_t                   strobe;

  assign ceVec[LEFT]    = lCeN;
  assign ceVec[RIGHT]   = rCeN;
  assign rwVec[LEFT]    = lRwN;
  assign rwVec[RIGHT]   = rRwN;
  assign oeVec[LEFT]    = lOeN;
  assign oeVec[RIGHT]   = rOeN;
  assign addrVec[LEFT]  = lAddr;
  assign addrVec[RIGHT] = rAddr;

  mailbox_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ceN   (ceVec),
    .rwN   (rwVec),
    .oeN   (oeVec),
    .addr  (addrVec),
    .strobe(strobe)
  );

  mailbox_irq_flags u_flags (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .intN  (intVec)
  );

  assign lIntN = intVec[LEFT];
  assign rIntN = intVec[RIGHT];
endmodule

// File: rtl/mailbox_irq_chk.sv
module mailbox_irq_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              lCeN,
  input logic              lRwN,
  input logic              lOeN,
  input logic [ADDR_W-1:0] lAddr,
  input logic              rCeN,
  input logic              rRwN,
  input logic              rOeN,
  input logic [ADDR_W-1:0] rAddr,
  input logic              lIntN,
  input logic              rIntN
);
  localparam logic [ADDR_W-1:0] BOX_R = '1;
  localparam logic [ADDR_W-1:0] BOX_L = BOX_R - ADDR_W'(1);

  logic live;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) live <= 1'b0;
    else       live <= 1'b1;
  end

  logic lWrBoxR, rWrBoxL, rRdBoxR, lRdBoxL, nearTop;
  assign lWrBoxR = !lCeN && !lRwN && lAddr == BOX_R;
  assign rWrBoxL = !rCeN && !rRwN && rAddr == BOX_L;
  assign rRdBoxR = !rCeN && !rOeN && rRwN && rAddr == BOX_R;
  assign lRdBoxL = !lCeN && !lOeN && lRwN && lAddr == BOX_L;
  assign nearTop = (lAddr >= BOX_L) || (rAddr >= BOX_L);

  p_reset_idle_r1: assert property (@(posedge clk) !rstN |=> (lIntN && rIntN));

  p_set_right_r2: assert property (@(posedge clk) disable iff (!rstN)
    lWrBoxR |=> !rIntN);

  p_set_left_r3: assert property (@(posedge clk) disable iff (!rstN)
    rWrBoxL |=> !lIntN);

  p_ack_right_r4: assert property (@(posedge clk) disable iff (!rstN)
    live && $past(rRdBoxR) && (rCeN || rOeN) && !lWrBoxR |=> rIntN);

  p_ack_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    live && $past(lRdBoxL) && (lCeN || lOeN) && !rWrBoxL |=> lIntN);

  p_quiet_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    live && !$past(nearTop) && !nearTop |=> ($stable(lIntN) && $stable(rIntN)));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    live && $past(rRdBoxR) && (rCeN || rOeN) && lWrBoxR |=> !rIntN);

  p_no_ack_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rCeN && !rOeN && !rIntN && !lWrBoxR |=> !rIntN);
endmodule

bind mailbox_irq mailbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .lCeN (lCeN),
  .lRwN (lRwN),
  .lOeN (lOeN),
  .lAddr(lAddr),
  .rCeN (rCeN),
  .rRwN (rRwN),
  .rOeN (rOeN),
  .rAddr(rAddr),
  .lIntN(lIntN),
  .rIntN(rIntN)
);

// File: tb/mailbox_irq_tb.sv
`timescale 1ns/1ps
module mailbox_irq_tb;
  localparam int AW = 10;
  localparam logic [AW-1:0] BOX_R = 10'h3FF;
  localparam logic [AW-1:0] BOX_L = 10'h3FE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lCeN = 1, lRwN = 1, lOeN = 1, rCeN = 1, rRwN = 1, rOeN = 1;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic lIntN, rIntN;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  // Behavioural reference (active-low expectations).
  bit expL = 1, expR = 1;
  bit heldL = 0, heldR = 0;

  always #2.5 clk = ~clk;

  mailbox_irq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN),
    .lCeN(lCeN), .lRwN(lRwN), .lOeN(lOeN), .lAddr(lAddr),
    .rCeN(rCeN), .rRwN(rRwN), .rOeN(rOeN), .rAddr(rAddr),
    .lIntN(lIntN), .rIntN(rIntN)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      expL = 1; expR = 1; heldL = 0; heldR = 0;
    end else begin
      bit msgToR, msgToL, ackR, ackL;
      msgToR = !lCeN && !lRwN && lAddr == BOX_R;
      msgToL = !rCeN && !rRwN && rAddr == BOX_L;
      ackR   = heldR && (rCeN || rOeN);
      ackL   = heldL && (lCeN || lOeN);
      if (msgToR) expR = 0; else if (ackR) expR = 1;
      if (msgToL) expL = 0; else if (ackL) expL = 1;
      heldR = !rCeN && !rOeN && rRwN && rAddr == BOX_R;
      heldL = !lCeN && !lOeN && lRwN && lAddr == BOX_L;
    end
  end

  always @(negedge clk) begin
    compared++;
    if (lIntN !== expL || rIntN !== expR) begin
      mismatched++;
      $display("FAIL %s (model): lIntN=%b rIntN=%b expected %b %b", curReq, lIntN, rIntN, expL, expR);
    end
  end

  task automatic expectInt(input string req, input bit eL, input bit eR);
    compared++;
    if (lIntN !== eL || rIntN !== eR) begin
      mismatched++;
      $display("FAIL %s: lIntN=%b rIntN=%b expected %b %b", req, lIntN, rIntN, eL, eR);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic driveL(input bit ce, input bit rw, input bit oe, input logic [AW-1:0] a);
    lCeN = ce; lRwN = rw; lOeN = oe; lAddr = a;
  endtask

  task automatic driveR(input bit ce, input bit rw, input bit oe, input logic [AW-1:0] a);
    rCeN = ce; rRwN = rw; rOeN = oe; rAddr = a;
  endtask

  task automatic idle();
    driveL(1, 1, 1, '0);
    driveR(1, 1, 1, '0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    step(3);
    expectInt("R1", 1, 1);
    rstN = 1;
    step(2);
    expectInt("R1", 1, 1);

    // R2: left writes right's mailbox (oe low, ignored)
    curReq = "R2";
    driveL(0, 0, 0, BOX_R); step(1); idle();
    expectInt("R2", 1, 0);
    step(2);
    expectInt("R2", 1, 0);

    // R4: held read does not clear; oe release clears
    curReq = "R4";
    driveR(0, 1, 0, BOX_R); step(3);
    expectInt("R4", 1, 0);
    driveR(0, 1, 1, BOX_R); step(1);
    expectInt("R4", 1, 1);
    idle(); step(1);

    // R3: right writes left's mailbox
    curReq = "R3";
    driveR(0, 0, 1, BOX_L); step(1); idle();
    expectInt("R3", 0, 1);

    // R5: left read then chip enable release clears
    curReq = "R5";
    driveL(0, 1, 0, BOX_L); step(2);
    expectInt("R5", 0, 1);
    driveL(1, 1, 0, BOX_L); step(1);
    expectInt("R5", 1, 1);
    idle(); step(1);

    // R6: own-mailbox writes do not set anything
    curReq = "R6";
    driveR(0, 0, 1, BOX_R); driveL(0, 0, 1, BOX_L); step(2); idle(); step(1);
    expectInt("R6", 1, 1);
    driveL(0, 0, 1, 10'h3FD); driveR(0, 0, 1, 10'h000); step(2); idle(); step(1);
    expectInt("R6", 1, 1);
    // set both, then reads of the wrong mailbox and other addresses
    driveL(0, 0, 1, BOX_R); driveR(0, 0, 1, BOX_L); step(1); idle();
    expectInt("R6", 0, 0);
    driveL(0, 1, 0, BOX_R); driveR(0, 1, 0, BOX_L); step(2); idle(); step(1);
    expectInt("R6", 0, 0);
    driveL(0, 1, 0, 10'h3FD); driveR(0, 1, 0, 10'h155); step(2); idle(); step(1);
    expectInt("R6", 0, 0);

    // R8: read ended by address move or rw flip does not acknowledge
    curReq = "R8";
    driveR(0, 1, 0, BOX_R); step(1);
    driveR(0, 1, 0, 10'h3FD); step(1);
    driveR(1, 1, 1, 10'h3FD); step(1);
    expectInt("R8", 0, 0);
    driveL(0, 1, 0, BOX_L); step(1);
    driveL(0, 0, 0, BOX_L); step(1);
    driveL(1, 1, 1, BOX_L); step(1);
    expectInt("R8", 0, 0);

    // R7: acknowledge coincides with a new message: set wins
    curReq = "R7";
    driveR(0, 1, 0, BOX_R); step(1);
    driveR(0, 1, 1, BOX_R); driveL(0, 0, 1, BOX_R); step(1); idle();
    expectInt("R7", 0, 0);
    driveL(0, 1, 0, BOX_L); step(1);
    driveL(0, 1, 1, BOX_L); driveR(0, 0, 1, BOX_L); step(1); idle();
    expectInt("R7", 0, 0);

    // clean acknowledges on both sides (R4, R5)
    curReq = "R4";
    driveR(0, 1, 0, BOX_R); driveL(0, 1, 0, BOX_L); step(1);
    idle(); step(1);
    expectInt("R4", 1, 1);

    // mixed traffic concentrated on the mailbox words, compared every clock
    curReq = "random";
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] aL, aR;
      int selL, selR;
      selL = $urandom_range(0, 3);
      selR = $urandom_range(0, 3);
      aL = (selL == 0) ? BOX_R : (selL == 1) ? BOX_L : (selL == 2) ? 10'h3FD : AW'($urandom);
      aR = (selR == 0) ? BOX_R : (selR == 1) ? BOX_L : (selR == 2) ? 10'h3FD : AW'($urandom);
      driveL(1'($urandom), 1'($urandom), 1'($urandom), aL);
      driveR(1'($urandom), 1'($urandom), 1'($urandom), aR);
      step(1);
    end
    idle(); step(2);

    summary();
    $finish;
  end
endmodule